// File: doc/BRIEF.md
# LIN Slave Header Receiver

This block watches a LIN bus line in slave mode and recognises the header that opens every frame: a long dominant break, a sync byte, then an identifier byte. The line is sampled on a tick that runs at sixteen times the bit rate. Until a complete and well-formed header has been seen, the block keeps the downstream receiver muted. On the last sample of the identifier's stop bit it releases mute, raises a header-detected flag and a data-ready flag, and reports the header length in whole bit times.

A header that is still unfinished after the time-out limit is abandoned. The block raises a header-error flag, forces the length value to zero and stays muted. It then waits for the line to return high before it looks for a new break. A time-out and a completion can never both happen for the same header, even when the time-out falls in the last samples of the identifier stop bit. A sync byte with the wrong value and a framing fault are also treated as header errors. Software can clear the flags with a strobe and can force the block back into mute at any time. The interrupt request is the OR of the three flags.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset `muted` is 1, `hdr_det`, `hdr_err`, `rx_ready` and `irq` are 0, and `hdr_len` is 0.
- R2: A break is accepted when at least BRK_BITS*OVS consecutive low samples (176 by default) are followed by a high sample. A shorter low run is ignored: it changes no flag, no length and no mute state.
- R3: After the break, the sync and identifier bytes are each framed as one low start bit, eight data bits sent LSB first and one high stop bit, each bit lasting OVS samples. Each bit is taken at its 8th sample, counted from the first low sample of the start bit.
- R4: If the sync byte is not 8'h55, the block sets `hdr_err` and loads `hdr_len` with 0. It sets neither `hdr_det` nor `rx_ready` and does not clear `muted`.
- R5: On the 16th sample of the identifier stop bit of a well-formed header, the block sets `hdr_det` and `rx_ready`, clears `muted`, and loads `hdr_len` with floor(N/16). N is the number of samples from the first break sample through that sample.
- R6: A header is given TO_BITS*OVS samples (912 by default), counted from the first break sample. If it has not completed by then, the next sample sets `hdr_err`, loads `hdr_len` with 0, leaves `muted` unchanged, and makes the block wait for a high line before it looks for a new break.
- R7: A time-out that falls on any sample of the identifier stop bit, including the 9th to 15th, never clears `muted` and never sets `hdr_det` or `rx_ready`. This holds even when `sw_clear` clears `hdr_err` before the stop bit ends.
- R8: A start bit sampled high, or a stop bit of either byte sampled low, is a header error with the same effects as R4.
- R9: `irq` is 1 exactly when at least one of `hdr_det`, `hdr_err` and `rx_ready` is 1.
- R10: A one-cycle `sw_clear` clears all three flags on the next clock edge. A flag being set in the same cycle takes priority.
- R11: `sw_mute_req` sets `muted` on the next edge, and it takes priority over a header completion in the same cycle.
- R12: Flags stay set until cleared, and `hdr_len` holds its value until the next completion or header error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_tick | input | 1 | One-cycle pulse, OVS per bit time |
| rx_in | input | 1 | Serial bus line, sampled on `samp_tick` |
| sw_clear | input | 1 | Clears the three flags |
| sw_mute_req | input | 1 | Forces mute |
| hdr_det | output | 1 | Header detected flag |
| hdr_err | output | 1 | Header error flag |
| rx_ready | output | 1 | Data-ready flag |
| muted | output | 1 | Receiver held in mute |
| hdr_len | output | LEN_W | Header length in bit times, 0 after an error |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. An error never coincides with a new detection or with mute being released. Mute is only released together with data-ready. An error leaves a zero length. The clear and mute requests take effect on the next edge, and flags rise only after a sample tick. Only the bench scenarios can show that the length value is correct and that the time-out boundary lands on the right sample. To do so, the bench sweeps the break and delimiter lengths and moves the time-out across every sample of the identifier stop bit. The same applies to rejection of short breaks, bad sync values and framing faults.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_BRK,
      ST_DELIM,
      ST_BYTE,
      ST_WAIT_HI
   } hdr_state_t;

   function automatic int samples_for(input int bits, input int ovs);
      return bits * ovs;
   endfunction
endpackage

// File: rtl/lin_hdr_len_ctr.sv
module lin_hdr_len_ctr #(
   parameter int LIMIT = 912,
   parameter int CW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start,
   input  logic          active,
   output logic [CW-1:0] cnt,
   output logic          at_limit
);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         if (start) begin
            cnt <= CW'(1);
         end else if (active && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign at_limit = (cnt == LIM);
endmodule

// File: rtl/lin_byte_sampler.sv
module lin_byte_sampler #(
   parameter int OVS     = 16,
   parameter int SMP_IDX = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       run,
   input  logic       restart,
   input  logic       rx,
   output logic       smp_pt,
   output logic       bit_end,
   output logic [3:0] bit_idx,
   output logic [7:0] data
);
   localparam int SW = $clog2(OVS);
   localparam logic [SW-1:0] PT  = SW'(SMP_IDX);
   localparam logic [SW-1:0] END = SW'(OVS - 1);

   logic [SW-1:0] smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp     <= '0;
         bit_idx <= '0;
      end else if (tick) begin
         if (restart) begin
            smp     <= SW'(1);
            bit_idx <= '0;
         end else if (run) begin
            if (smp == END) begin
               smp     <= '0;
               bit_idx <= bit_idx + 4'd1;
            end else begin
               smp <= smp + 1'b1;
            end
         end
      end
   end

   assign smp_pt  = tick && run && !restart && (smp == PT);
   assign bit_end = tick && run && !restart && (smp == END);

   for (genvar i = 0; i < 8; i++) begin : g_dbit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data[i] <= 1'b0;
         end else if (smp_pt && (bit_idx == 4'(i + 1))) begin
            data[i] <= rx;
         end
      end
   end
endmodule

// File: rtl/lin_hdr_ctl.sv
module lin_hdr_ctl
   import lin_hdr_pkg::*;
#(
   parameter int         OVS      = 16,
   parameter int         BRK_SAMP = 176,
   parameter int         CW       = 10,
   parameter int         LEN_W    = 8,
   parameter logic [7:0] SYNC_VAL = 8'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             rx,
   input  logic             sw_clear,
   input  logic             sw_mute_req,
   input  logic [CW-1:0]    cnt,
   input  logic             at_limit,
   input  logic             smp_pt,
   input  logic             bit_end,
   input  logic [3:0]       bit_idx,
   input  logic [7:0]       data,
   output logic             start,
   output logic             active,
   output logic             run,
   output logic             restart,
   output logic             hdr_det,
   output logic             hdr_err,
   output logic             rx_ready,
   output logic             muted,
   output logic [LEN_W-1:0] hdr_len
);
   hdr_state_t state, nxt;
   logic byte_sel;
   logic set_ok, set_err, tmo, brk_ok, field_err, last_end;

   assign active    = (state == ST_BRK) || (state == ST_DELIM) || (state == ST_BYTE);
   assign start     = (state == ST_IDLE) && !rx;
   assign restart   = (state == ST_DELIM) && !rx;
   assign run       = (state == ST_BYTE);
   assign tmo       = tick && active && at_limit;
   assign brk_ok    = (cnt >= CW'(BRK_SAMP));
   assign last_end  = bit_end && (bit_idx == 4'd9);
   assign field_err = smp_pt && (((bit_idx == 4'd0) && rx) ||
                      ((bit_idx == 4'd9) && (!rx || (!byte_sel && (data != SYNC_VAL)))));

   always_comb begin
      nxt     = state;
      set_ok  = 1'b0;
      set_err = 1'b0;
      if (tmo) begin
         nxt     = ST_WAIT_HI;
         set_err = 1'b1;
      end else if (tick) begin
         case (state)
            ST_IDLE:    if (!rx) nxt = ST_BRK;
            ST_BRK:     if (rx) nxt = brk_ok ? ST_DELIM : ST_IDLE;
            ST_DELIM:   if (!rx) nxt = ST_BYTE;
            ST_BYTE: begin
               if (field_err) begin
                  nxt     = ST_WAIT_HI;
                  set_err = 1'b1;
               end else if (last_end) begin
                  if (byte_sel) begin
                     nxt    = ST_IDLE;
                     set_ok = 1'b1;
                  end else begin
                     nxt = ST_DELIM;
                  end
               end
            end
            ST_WAIT_HI: if (rx) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         byte_sel <= 1'b0;
         hdr_det  <= 1'b0;
         hdr_err  <= 1'b0;
         rx_ready <= 1'b0;
         muted    <= 1'b1;
         hdr_len  <= '0;
      end else begin
         state <= nxt;
         if (tick && (state == ST_BRK)) begin
            byte_sel <= 1'b0;
         end else if (tick && (state == ST_BYTE) && last_end && !tmo) begin
            byte_sel <= 1'b1;
         end
         hdr_det  <= set_ok  | (hdr_det  & ~sw_clear);
         rx_ready <= set_ok  | (rx_ready & ~sw_clear);
         hdr_err  <= set_err | (hdr_err  & ~sw_clear);
         if (sw_mute_req) begin
            muted <= 1'b1;
         end else if (set_ok) begin
            muted <= 1'b0;
         end
         if (set_err) begin
            hdr_len <= '0;
         end else if (set_ok) begin
            hdr_len <= LEN_W'((32'(cnt) + 32'd1) / 32'(OVS));
         end
      end
   end
endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
   import lin_hdr_pkg::*;
#(
   parameter int         OVS      = 16,
   parameter int         BRK_BITS = 11,
   parameter int         TO_BITS  = 57,
   parameter int         LEN_W    = 8,
   parameter logic [7:0] SYNC_VAL = 8'h55
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             samp_tick,
   input  logic             rx_in,
   input  logic             sw_clear,
   input  logic             sw_mute_req,
   output logic             hdr_det,
   output logic             hdr_err,
   output logic             rx_ready,
   output logic             muted,
   output logic [LEN_W-1:0] hdr_len,
   output logic             irq
);
   localparam int BRK_SAMP = samples_for(BRK_BITS, OVS);
   localparam int TO_SAMP  = samples_for(TO_BITS, OVS);
   localparam int CW       = $clog2(TO_SAMP + 1);
   localparam int SMP_IDX  = OVS / 2 - 1;

   if ((OVS < 4) || ((1 << $clog2(OVS)) != OVS)) begin : g_bad_ovs
      $error("OVS must be a power of two, at least 4");
   end
   if (TO_BITS <= BRK_BITS + 21) begin : g_bad_to
      $error("TO_BITS too small to hold a header");
   end
   if (TO_BITS >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for TO_BITS");
   end

   logic [CW-1:0] cnt;
   logic          at_limit, start, active, run, restart;
   logic          smp_pt, bit_end;
   logic [3:0]    bit_idx;
   logic [7:0]    data;

   lin_hdr_len_ctr #(.LIMIT(TO_SAMP), .CW(CW)) u_len (
      .clk(clk), .rst_n(rst_n), .tick(samp_tick), .start(start),
      .active(active), .cnt(cnt), .at_limit(at_limit)
   );

   lin_byte_sampler #(.OVS(OVS), .SMP_IDX(SMP_IDX)) u_smp (
      .clk(clk), .rst_n(rst_n), .tick(samp_tick), .run(run),
      .restart(restart), .rx(rx_in), .smp_pt(smp_pt), .bit_end(bit_end),
      .bit_idx(bit_idx), .data(data)
   );

   lin_hdr_ctl #(.OVS(OVS), .BRK_SAMP(BRK_SAMP), .CW(CW), .LEN_W(LEN_W),
                 .SYNC_VAL(SYNC_VAL)) u_ctl (
      .clk(clk), .rst_n(rst_n), .tick(samp_tick), .rx(rx_in),
      .sw_clear(sw_clear), .sw_mute_req(sw_mute_req), .cnt(cnt),
      .at_limit(at_limit), .smp_pt(smp_pt), .bit_end(bit_end),
      .bit_idx(bit_idx), .data(data), .start(start), .active(active),
      .run(run), .restart(restart), .hdr_det(hdr_det), .hdr_err(hdr_err),
      .rx_ready(rx_ready), .muted(muted), .hdr_len(hdr_len)
   );

   assign irq = hdr_det | hdr_err | rx_ready;
endmodule

// File: rtl/lin_hdr_rx_chk.sv
module lin_hdr_rx_chk #(
   parameter int TO_BITS = 57,
   parameter int LEN_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             samp_tick,
   input logic             sw_clear,
   input logic             sw_mute_req,
   input logic             hdr_det,
   input logic             hdr_err,
   input logic             rx_ready,
   input logic             muted,
   input logic [LEN_W-1:0] hdr_len,
   input logic             irq
);
   p_err_keeps_mute_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hdr_err) |-> !$fell(muted));

   p_err_len_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hdr_err) |-> (hdr_len == '0));

   p_err_excl_det_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hdr_err) |-> (!$rose(hdr_det) && !$rose(rx_ready)));

   p_unmute_with_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(muted) |-> (rx_ready && hdr_det));

   p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_len <= LEN_W'(TO_BITS));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clear && !samp_tick) |=> (!hdr_det && !hdr_err && !rx_ready));

   p_mute_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sw_mute_req |=> muted);

   p_irq_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(samp_tick));
endmodule

bind lin_hdr_rx lin_hdr_rx_chk #(.TO_BITS(TO_BITS), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_lin_hdr_rx.sv
module tb_lin_hdr_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       sw_clear = 1'b0;
   logic       sw_mute_req = 1'b0;
   logic       hdr_det, hdr_err, rx_ready, muted, irq;
   logic [7:0] hdr_len;

   int n_tests = 0;
   int n_fail  = 0;
   int samp_no = 0;
   int clr_at  = -1;
   int mute_at = -1;

   always #4 clk = ~clk;

   lin_hdr_rx dut (
      .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rx_in(rx_in),
      .sw_clear(sw_clear), .sw_mute_req(sw_mute_req), .hdr_det(hdr_det),
      .hdr_err(hdr_err), .rx_ready(rx_ready), .muted(muted),
      .hdr_len(hdr_len), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic sample(input logic v);
      @(negedge clk);
      samp_no++;
      rx_in       = v;
      samp_tick   = 1'b1;
      sw_clear    = 1'b0;
      sw_mute_req = (samp_no == mute_at);
      @(negedge clk);
      samp_tick   = 1'b0;
      sw_mute_req = 1'b0;
      sw_clear    = (samp_no == clr_at);
   endtask

   task automatic samples(input logic v, input int n);
      for (int i = 0; i < n; i++) sample(v);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic stop_v);
      samples(1'b0, 16);
      for (int i = 0; i < 8; i++) samples(b[i], 16);
      samples(stop_v, 16);
   endtask

   task automatic send_header(input int brk, input int ds, input logic [7:0] sy,
                              input logic [7:0] id, input logic id_stop);
      samples(1'b1, 6);
      samp_no = 0;
      samples(1'b0, brk);
      samples(1'b1, ds);
      send_byte(sy, 1'b1);
      send_byte(id, id_stop);
   endtask

   task automatic pulse(input logic is_mute);
      @(negedge clk);
      if (is_mute) sw_mute_req = 1'b1; else sw_clear = 1'b1;
      @(negedge clk);
      sw_mute_req = 1'b0;
      sw_clear    = 1'b0;
   endtask

   task automatic fresh();
      pulse(1'b0);
      pulse(1'b1);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=running exp=done");
      finish_run();
   end

   initial begin
      int brks[4] = '{176, 192, 208, 256};
      int dels[4] = '{1, 9, 16, 33};
      logic [7:0] bad[4] = '{8'h54, 8'hAA, 8'hD5, 8'h00};
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 muted", muted, 1);
      chk("R1 hdr_det", hdr_det, 0);
      chk("R1 hdr_err", hdr_err, 0);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 irq", irq, 0);
      chk("R1 hdr_len", hdr_len, 0);

      // R2 break one sample short is ignored
      samples(1'b1, 4);
      samples(1'b0, 175);
      samples(1'b1, 30);
      send_byte(8'h55, 1'b1);
      send_byte(8'h3C, 1'b1);
      samples(1'b1, 8);
      chk("R2 short break det", hdr_det, 0);
      chk("R2 short break err", hdr_err, 0);
      chk("R2 short break muted", muted, 1);
      chk("R2 short break len", hdr_len, 0);
      chk("R2 short break irq", irq, 0);

      // R3 R5 R9 valid headers over break and delimiter sweep
      for (int b = 0; b < 4; b++) begin
         for (int d = 0; d < 4; d++) begin
            fresh();
            send_header(brks[b], dels[d], 8'h55, 8'(8'h11 * (b + d)), 1'b1);
            n = brks[b] + dels[d] + 320;
            chk("R5 det", hdr_det, 1);
            chk("R5 ready", rx_ready, 1);
            chk("R5 unmuted", muted, 0);
            chk("R3 no err", hdr_err, 0);
            chk("R9 irq", irq, 1);
            chk("R5 len", hdr_len, n / 16);
         end
      end

      // R12 flags and length hold
      samples(1'b1, 40);
      chk("R12 det held", hdr_det, 1);
      chk("R12 len held", hdr_len, (256 + 33 + 320) / 16);

      // R10 clear
      pulse(1'b0);
      chk("R10 det cleared", hdr_det, 0);
      chk("R10 ready cleared", rx_ready, 0);
      chk("R9 irq low", irq, 0);
      chk("R12 len after clear", hdr_len, 38);

      // R11 mute request
      pulse(1'b1);
      chk("R11 muted", muted, 1);
      fresh();
      mute_at = 176 + 16 + 320;
      send_header(176, 16, 8'h55, 8'h20, 1'b1);
      mute_at = -1;
      chk("R11 mute wins", muted, 1);
      chk("R11 det still set", hdr_det, 1);

      // R4 bad sync values
      for (int k = 0; k < 4; k++) begin
         fresh();
         send_header(192, 16, 8'h55, 8'h01, 1'b1);
         chk("R4 pre len", hdr_len, 33);
         fresh();
         send_header(192, 16, bad[k], 8'h01, 1'b1);
         samples(1'b1, 4);
         chk("R4 err", hdr_err, 1);
         chk("R4 len", hdr_len, 0);
         chk("R4 det", hdr_det, 0);
         chk("R4 ready", rx_ready, 0);
         chk("R4 muted", muted, 1);
      end

      // R8 identifier stop bit low
      fresh();
      send_header(192, 16, 8'h55, 8'h7E, 1'b0);
      samples(1'b1, 4);
      chk("R8 err", hdr_err, 1);
      chk("R8 det", hdr_det, 0);
      chk("R8 muted", muted, 1);

      // R6 break never ends
      fresh();
      send_header(176, 16, 8'h55, 8'h01, 1'b1);
      fresh();
      samples(1'b1, 4);
      samples(1'b0, 960);
      chk("R6 err", hdr_err, 1);
      chk("R6 len", hdr_len, 0);
      chk("R6 muted", muted, 1);
      chk("R6 det", hdr_det, 0);
      samples(1'b1, 10);
      chk("R6 waits", muted, 1);

      // R7 time-out swept across the identifier stop bit
      for (int ds = 380; ds <= 400; ds++) begin
         n = 208 + ds + 320;
         fresh();
         clr_at = (n >= 915) ? 914 : -1;
         send_header(208, ds, 8'h55, 8'h3C, 1'b1);
         clr_at = -1;
         samples(1'b1, 4);
         if (n <= 912) begin
            chk("R7 edge det", hdr_det, 1);
            chk("R7 edge muted", muted, 0);
            chk("R7 edge len", hdr_len, n / 16);
         end else begin
            chk("R7 err", hdr_err, (n >= 915) ? 0 : 1);
            chk("R7 det", hdr_det, 0);
            chk("R7 ready", rx_ready, 0);
            chk("R7 muted", muted, 1);
            chk("R7 len", hdr_len, 0);
         end
      end

      finish_run();
   end
endmodule